// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a system clock into the time base of a CAN node. A prescaler divides the clock into time quanta. A segment sequencer splits each bit into a one-quantum synchronisation segment, a first timing segment and a second timing segment. At the boundary between the two timing segments it samples the bus. The block emits a one-cycle pulse for every quantum, for the sample point and for the start of every bit. It also holds the bus value taken at the most recent sample point.

Two configuration words set the time base: a prescaler word and a packed timing word. The fields are stored as value minus one, and the prescaler has a floor of four clocks. Both words can be written only while the configuration-mode input is high, and the time base stays idle during that time. In normal operation, a recessive-to-dominant transition on the bus moves the bit boundaries. A transition in the first segment stretches it, and a transition in the second segment cuts it short, each by no more than the jump width. An optional mode replaces the single sample with a two-of-three vote over three consecutive clock samples.

Top module: `can_bit_timer`

## Requirements
- R1: While `rst` or `cfg_mode` is high, `tq_tick`, `sample_tick` and `bit_start` stay 0 and `rx_bit` reads 1 (recessive). Both configuration words reset to 0.
- R2: The quantum length is BRP = `presc_q` + 1 clocks, and any value below 4 is raised to 4. `tq_tick` is a one-cycle pulse once per quantum.
- R3: With T1 = timing[3:0] + 1 and T2 = timing[6:4] + 1, and with no resynchronisation, consecutive `bit_start` pulses are BRP × (1 + T1 + T2) clocks apart.
- R4: `sample_tick` pulses BRP × (1 + T1) clocks after `bit_start`, plus any extension from R8. The two pulses never coincide.
- R5: Writes through `presc_wr` or `timing_wr` while `cfg_mode` is low leave the configuration unchanged.
- R6: With timing[7] = 0, at each sample point `rx_bit` takes the value `bus_rx` had two clocks earlier. Between sample points `rx_bit` holds its value.
- R7: With timing[7] = 1, `rx_bit` takes the two-of-three majority of `bus_rx` as seen two, three and four clocks before the sample point.
- R8: A qualified falling edge in quantum i of the first segment (i = 1 for the first quantum after sync) lengthens that segment by min(i, SJW), where SJW = timing[9:8] + 1.
- R9: A qualified falling edge in quantum j of the second segment (j = 0 first) shortens that segment by min(T2 − 1 − j, SJW).
- R10: A falling edge is qualified only if `rx_bit` is 1 and no qualified edge has occurred since the last sample point. Unqualified edges leave the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration mode: unlocks writes and holds the time base idle |
| presc_wr | input | 1 | Prescaler word write strobe |
| presc_data | input | 10 | Prescaler word, BRP minus one |
| timing_wr | input | 1 | Timing word write strobe |
| timing_data | input | 10 | Timing word: [3:0] T1−1, [6:4] T2−1, [7] triple sample, [9:8] SJW−1 |
| bus_rx | input | 1 | Received bus level, 1 = recessive |
| tq_tick | output | 1 | One pulse per time quantum |
| sample_tick | output | 1 | Pulse at the sample point |
| bit_start | output | 1 | Pulse at the start of each bit's sync quantum |
| rx_bit | output | 1 | Bus value taken at the last sample point |

## Verification
The bench places falling edges in chosen quanta. It uses the first quantum of the first segment and quanta of the second segment with remaining phase error above, below and at zero. A sequencer that measured the phase error from the wrong end, or that ignored the jump-width limit, would move the sample point or the next bit start by one or more quanta. It sends a second edge in the same bit, and an edge after a dominant sample, to expose a design that resynchronises more than once or on any edge. It also sends one- and two-clock glitches right before the sample point to separate single sampling from the majority vote. Finally, it sets prescaler values below the floor and writes words outside configuration mode, which expose a missing clamp or a missing write lock as a wrong quantum or bit length.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_TSEG1 = 2'd1,
    PH_TSEG2 = 2'd2
  } bt_phase_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W   = 10,
  parameter int BRP_MIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [BRP_W-1:0] brp_field,
  output logic             tq_end
);
  localparam logic [BRP_W-1:0] LAST_MIN = BRP_W'(BRP_MIN - 1);

  logic [BRP_W-1:0] pc;
  logic [BRP_W-1:0] last;

  always_comb begin
    last   = (brp_field < LAST_MIN) ? LAST_MIN : brp_field;
    tq_end = !hold && (pc == last);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      pc <= '0;
    end else if (tq_end) begin
      pc <= '0;
    end else begin
      pc <= pc + BRP_W'(1);
    end
  end

  // R2: the quantum is at least BRP_MIN clocks, so ends are never adjacent
  assert_tq_gap_R2: assert property (@(posedge clk) disable iff (rst || hold)
    tq_end |=> !tq_end);

  // R2: the divider never runs past the clamped terminal count
  assert_pc_range_R2: assert property (@(posedge clk) disable iff (rst || hold)
    pc <= last);

endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic bus_rx,
  input  logic triple,
  input  logic sample_now,
  output logic fall_edge,
  output logic rx_bit
);
  logic sync1, sync2, hist1, hist2;
  logic picked;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      hist1 <= 1'b1;
      hist2 <= 1'b1;
    end else begin
      sync1 <= bus_rx;
      sync2 <= sync1;
      hist1 <= sync2;
      hist2 <= hist1;
    end
  end

  always_comb begin
    fall_edge = hist1 & ~sync2;
    picked    = triple ? vote3(sync2, hist1, hist2) : sync2;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      rx_bit <= 1'b1;
    end else if (sample_now) begin
      rx_bit <= picked;
    end
  end

  // R6: the sampled bit moves only at a sample point
  assert_bit_held_R6: assert property (@(posedge clk) disable iff (rst || hold)
    !sample_now |=> $stable(rx_bit));

  // R7: with all three votes agreeing, the vote equals the newest sample
  assert_vote_agree_R7: assert property (@(posedge clk) disable iff (rst || hold)
    (sample_now && triple && (sync2 == hist1) && (hist1 == hist2)) |=> (rx_bit == $past(sync2)));

endmodule

// File: rtl/can_bt_segment.sv
module can_bt_segment
  import can_bt_pkg::*;
#(
  parameter int SEG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tq_end,
  input  logic [SEG_W-1:0] t1_nom,
  input  logic [SEG_W-1:0] t2_nom,
  input  logic [SEG_W-1:0] sjw,
  input  logic             fall_edge,
  input  logic             prev_bit,
  output logic             sample_now,
  output logic             sample_tick,
  output logic             bit_start
);
  bt_phase_e        phase;
  logic [SEG_W-1:0] qcnt, qnext;
  logic [SEG_W-1:0] seg1_len, seg2_len;
  logic [SEG_W-1:0] t1_lim, t2_lim;
  logic [SEG_W-1:0] perr, adj;
  logic             resync_ok, edge_q, t2_done;

  always_comb begin
    qnext = qcnt + SEG_W'(1);
    perr  = '0;
    if (phase == PH_TSEG1) begin
      perr = qnext;
    end else if (phase == PH_TSEG2 && seg2_len > qnext) begin
      perr = seg2_len - qnext;
    end
    adj    = (perr > sjw) ? sjw : perr;
    edge_q = fall_edge && prev_bit && resync_ok;
    t1_lim = seg1_len;
    t2_lim = seg2_len;
    if (edge_q && phase == PH_TSEG1) t1_lim = seg1_len + adj;
    if (edge_q && phase == PH_TSEG2) t2_lim = seg2_len - adj;
    sample_now = tq_end && (phase == PH_TSEG1) && (qnext >= t1_lim);
    t2_done    = tq_end && (phase == PH_TSEG2) && (qnext >= t2_lim);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      phase       <= PH_TSEG2;
      qcnt        <= '0;
      seg1_len    <= t1_nom;
      seg2_len    <= SEG_W'(1);
      resync_ok   <= 1'b1;
      sample_tick <= 1'b0;
      bit_start   <= 1'b0;
    end else begin
      sample_tick <= 1'b0;
      bit_start   <= 1'b0;
      seg1_len    <= t1_lim;
      seg2_len    <= t2_lim;
      if (edge_q) resync_ok <= 1'b0;
      if (tq_end) begin
        unique case (phase)
          PH_SYNC: begin
            phase <= PH_TSEG1;
            qcnt  <= '0;
          end
          PH_TSEG1: begin
            if (sample_now) begin
              phase       <= PH_TSEG2;
              qcnt        <= '0;
              sample_tick <= 1'b1;
              resync_ok   <= 1'b1;
            end else begin
              qcnt <= qnext;
            end
          end
          default: begin
            if (t2_done) begin
              phase     <= PH_SYNC;
              qcnt      <= '0;
              bit_start <= 1'b1;
              seg1_len  <= t1_nom;
              seg2_len  <= t2_nom;
            end else begin
              qcnt <= qnext;
            end
          end
        endcase
      end
    end
  end

  // R4: the sample point and the bit start are distinct instants
  assert_markers_apart_R4: assert property (@(posedge clk) disable iff (rst || hold)
    !(sample_tick && bit_start));

  // R4: the sample pulse marks entry into the second segment
  assert_sample_entry_R4: assert property (@(posedge clk) disable iff (rst || hold)
    sample_tick |-> (phase == PH_TSEG2 && qcnt == '0));

  // R3: every bit start opens a sync quantum
  assert_start_sync_R3: assert property (@(posedge clk) disable iff (rst || hold)
    bit_start |-> (phase == PH_SYNC));

  // R8: the first segment never grows past its nominal length plus the jump width
  assert_stretch_bound_R8: assert property (@(posedge clk) disable iff (rst || hold)
    (phase == PH_TSEG1) |-> (seg1_len <= t1_nom + sjw));

  // R10: at most one qualified edge between two sample points
  assert_one_resync_R10: assert property (@(posedge clk) disable iff (rst || hold)
    (edge_q && !sample_now) |=> !edge_q);

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int BRP_W   = 10,
  parameter int BRP_MIN = 4,
  parameter int T1_W    = 4,
  parameter int T2_W    = 3,
  parameter int SJW_W   = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_mode,
  input  logic                               presc_wr,
  input  logic [BRP_W-1:0]                   presc_data,
  input  logic                               timing_wr,
  input  logic [T1_W+T2_W+SJW_W:0]           timing_data,
  input  logic                               bus_rx,
  output logic                               tq_tick,
  output logic                               sample_tick,
  output logic                               bit_start,
  output logic                               rx_bit
);
  localparam int T1_LSB  = 0;
  localparam int T2_LSB  = T1_W;
  localparam int TRI_BIT = T1_W + T2_W;
  localparam int SJW_LSB = TRI_BIT + 1;
  localparam int TIM_W   = SJW_LSB + SJW_W;
  localparam int SEG_W   = ((T1_W > T2_W) ? T1_W : T2_W) + 2;

  logic [BRP_W-1:0] presc_q;
  logic [TIM_W-1:0] timing_q;
  logic [SEG_W-1:0] t1_nom, t2_nom, sjw_len;
  logic             tq_end, sample_now, fall_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q  <= '0;
      timing_q <= '0;
    end else if (cfg_mode) begin
      if (presc_wr)  presc_q  <= presc_data;
      if (timing_wr) timing_q <= timing_data;
    end
  end

  always_comb begin
    t1_nom  = SEG_W'(timing_q[T1_LSB +: T1_W]) + SEG_W'(1);
    t2_nom  = SEG_W'(timing_q[T2_LSB +: T2_W]) + SEG_W'(1);
    sjw_len = SEG_W'(timing_q[SJW_LSB +: SJW_W]) + SEG_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_mode) tq_tick <= 1'b0;
    else                 tq_tick <= tq_end;
  end

  can_bt_prescaler #(.BRP_W(BRP_W), .BRP_MIN(BRP_MIN)) u_presc (
    .clk       (clk),
    .rst       (rst),
    .hold      (cfg_mode),
    .brp_field (presc_q),
    .tq_end    (tq_end)
  );

  can_bt_sampler u_samp (
    .clk        (clk),
    .rst        (rst),
    .hold       (cfg_mode),
    .bus_rx     (bus_rx),
    .triple     (timing_q[TRI_BIT]),
    .sample_now (sample_now),
    .fall_edge  (fall_edge),
    .rx_bit     (rx_bit)
  );

  can_bt_segment #(.SEG_W(SEG_W)) u_seg (
    .clk         (clk),
    .rst         (rst),
    .hold        (cfg_mode),
    .tq_end      (tq_end),
    .t1_nom      (t1_nom),
    .t2_nom      (t2_nom),
    .sjw         (sjw_len),
    .fall_edge   (fall_edge),
    .prev_bit    (rx_bit),
    .sample_now  (sample_now),
    .sample_tick (sample_tick),
    .bit_start   (bit_start)
  );

  // R5: outside configuration mode both words are frozen
  assert_cfg_lock_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> ($stable(presc_q) && $stable(timing_q)));

  // R1: no strobe leaves the block while it is held in configuration mode
  assert_idle_cfg_R1: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_mode) |-> !(tq_tick || sample_tick || bit_start));

endmodule

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_mode = 1'b0;
  logic       presc_wr = 1'b0;
  logic [9:0] presc_data = '0;
  logic       timing_wr = 1'b0;
  logic [9:0] timing_data = '0;
  logic       bus_rx = 1'b1;
  logic       tq_tick, sample_tick, bit_start, rx_bit;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  can_bit_timer uut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
    .presc_wr(presc_wr), .presc_data(presc_data),
    .timing_wr(timing_wr), .timing_data(timing_data),
    .bus_rx(bus_rx), .tq_tick(tq_tick), .sample_tick(sample_tick),
    .bit_start(bit_start), .rx_bit(rx_bit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int brp_of(input int p);
    return (p < 3) ? 4 : p + 1;
  endfunction

  function automatic int tim_word(input int t1f, input int t2f, input int tri3, input int sjwf);
    return (sjwf << 8) | (tri3 << 7) | (t2f << 4) | t1f;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic configure(input int p, input int t);
    @(negedge clk);
    cfg_mode = 1'b1; presc_wr = 1'b1; timing_wr = 1'b1;
    presc_data = 10'(p); timing_data = 10'(t);
    @(negedge clk);
    presc_wr = 1'b0; timing_wr = 1'b0;
    @(negedge clk);
    cfg_mode = 1'b0;
  endtask

  task automatic wait_bs(output int at);
    do @(negedge clk); while (!bit_start);
    at = cyc;
  endtask

  task automatic wait_sp(output int at);
    do @(negedge clk); while (!sample_tick);
    at = cyc;
  endtask

  task automatic wait_tq(output int at);
    do @(negedge clk); while (!tq_tick);
    at = cyc;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic settle();
    int e;
    wait_bs(e);
    wait_bs(e);
  endtask

  // quanta with BRP 4, T1 8, T2 6, SJW 2 used by the resync cases
  task automatic t1_edge(input int k, input int ext, input string tag);
    int e, s, e2;
    settle();
    wait_bs(e);
    wait_cyc(e + k * 4 - 1);
    bus_rx = 1'b0;
    wait_sp(s);
    chk({tag, " sample offset"}, s - e, 4 * (9 + ext));
    @(negedge clk);
    chk("R6 dominant sampled", int'(rx_bit), 0);
    wait_bs(e2);
    chk({tag, " bit length"}, e2 - e, 4 * (15 + ext));
    bus_rx = 1'b1;
  endtask

  task automatic t2_edge(input int j, input int cut, input string tag);
    int e, s, e2;
    settle();
    wait_bs(e);
    wait_sp(s);
    wait_cyc(e + 4 * (9 + j) - 1);
    bus_rx = 1'b0;
    wait_bs(e2);
    chk({tag, " bit length"}, e2 - e, 4 * (15 - cut));
    @(negedge clk);
    bus_rx = 1'b1;
  endtask

  // glitch_mask bit g drives recessive for the value seen g+2 clocks before the sample point
  task automatic glitch_trial(input int mask, input int exp_bit, input string tag);
    int e, s, nxt;
    bus_rx = 1'b0;
    settle();
    wait_sp(s);
    nxt = s + 32;
    for (int g = 3; g >= 0; g--) begin
      wait_cyc(nxt - g - 3);
      bus_rx = mask[g] ? 1'b1 : 1'b0;
    end
    wait_cyc(nxt - 2);
    bus_rx = 1'b0;
    wait_sp(s);
    chk({tag, " sample time"}, s, nxt);
    @(negedge clk);
    chk(tag, int'(rx_bit), exp_bit);
    wait_bs(e);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b, e, s, e2, p, t1f, t2f, unused;
    unused = int'($urandom(32'd7717));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 tq in reset", int'(tq_tick), 0);
    chk("R1 sample in reset", int'(sample_tick), 0);
    chk("R1 start in reset", int'(bit_start), 0);
    chk("R1 rx_bit in reset", int'(rx_bit), 1);
    rst = 1'b0;

    // R3 with reset defaults: BRP 4, T1 1, T2 1
    wait_bs(e); wait_bs(e2);
    chk("R3 default bit length", e2 - e, 12);

    // R1: idle in configuration mode, even with a dominant bus
    @(negedge clk); cfg_mode = 1'b1; bus_rx = 1'b0;
    a = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tq_tick || sample_tick || bit_start) a++;
    end
    chk("R1 strobes in config", a, 0);
    chk("R1 rx_bit in config", int'(rx_bit), 1);
    cfg_mode = 1'b0; bus_rx = 1'b1;

    // R2: quantum length and floor
    foreach (p_list[i]) begin
      configure(p_list[i], 0);
      wait_tq(a);
      @(negedge clk);
      chk("R2 tq single pulse", int'(tq_tick), 0);
      wait_tq(b);
      chk("R2 tq period", b - a, brp_of(p_list[i]));
    end

    // R3 R4: random configurations
    for (int n = 0; n < 12; n++) begin
      p   = int'($urandom % 12);
      t1f = int'($urandom % 16);
      t2f = int'($urandom % 8);
      configure(p, tim_word(t1f, t2f, 0, int'($urandom % 4)));
      wait_bs(e); wait_bs(e);
      wait_sp(s); wait_bs(e2);
      chk("R4 random sample offset", s - e, brp_of(p) * (1 + t1f + 1));
      chk("R3 random bit length", e2 - e, brp_of(p) * (3 + t1f + t2f));
    end

    // R2 R3: widest prescaler
    configure(1023, 0);
    wait_bs(e); wait_sp(s); wait_bs(e2);
    chk("R4 max prescaler sample", s - e, 2048);
    chk("R3 max prescaler bit", e2 - e, 3072);

    // R5: writes outside configuration mode are dropped
    configure(3, 0);
    @(negedge clk);
    presc_wr = 1'b1; timing_wr = 1'b1; presc_data = 10'd9; timing_data = 10'h077;
    @(negedge clk);
    presc_wr = 1'b0; timing_wr = 1'b0;
    wait_bs(e); wait_sp(s); wait_bs(e2);
    chk("R5 locked bit length", e2 - e, 12);
    chk("R5 locked sample", s - e, 8);

    // R8 R9 R10: resynchronisation, BRP 4, T1 8, T2 6, SJW 2
    configure(3, tim_word(7, 5, 0, 1));
    settle();
    wait_bs(e); wait_sp(s); wait_bs(e2);
    chk("R4 nominal sample", s - e, 36);
    chk("R3 nominal bit", e2 - e, 60);
    t1_edge(1, 1, "R8 first quantum");
    t1_edge(5, 2, "R8 jump limited");
    t2_edge(0, 2, "R9 jump limited");
    t2_edge(4, 1, "R9 small error");
    t2_edge(5, 0, "R9 last quantum");

    // R10: second edge in the same bit is ignored
    settle();
    wait_bs(e);
    wait_cyc(e + 3);  bus_rx = 1'b0;
    wait_cyc(e + 7);  bus_rx = 1'b1;
    wait_cyc(e + 11); bus_rx = 1'b0;
    wait_sp(s); wait_bs(e2);
    chk("R10 second edge sample", s - e, 40);
    chk("R10 second edge bit", e2 - e, 64);
    bus_rx = 1'b1;

    // R10: no resync after a dominant sample
    bus_rx = 1'b0;
    settle();
    wait_bs(e);
    wait_cyc(e + 3);  bus_rx = 1'b1;
    wait_cyc(e + 11); bus_rx = 1'b0;
    wait_sp(s); wait_bs(e2);
    chk("R10 dominant previous sample", s - e, 36);
    chk("R10 dominant previous bit", e2 - e, 60);
    chk("R10 rx_bit stays dominant", int'(rx_bit), 0);
    bus_rx = 1'b1;

    // R6 R7: single sample versus majority, BRP 4, T1 4, T2 3
    configure(3, tim_word(3, 2, 0, 0));
    glitch_trial(4'b0001, 1, "R6 one clock glitch single");
    configure(3, tim_word(3, 2, 1, 0));
    glitch_trial(4'b0001, 0, "R7 one clock glitch voted out");
    glitch_trial(4'b0011, 1, "R7 two clock glitch wins");
    glitch_trial(4'b0101, 1, "R7 split glitch wins");
    glitch_trial(4'b1000, 0, "R7 glitch outside window");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int p_list[4] = '{0, 2, 3, 6};

endmodule